// File: doc/BRIEF.md
# Serially Clocked SAR Conversion Sequencer

This block holds the digital half of a successive-approximation converter whose pace is set by an external host. The host pulls chip select low to freeze the input sample. It then toggles the serial clock, and each rising edge settles one result bit. That bit leaves on the serial data output as soon as it is known. The analog parts stay outside the block: the sample capacitor, the trial DAC and the comparator. The block drives a track/hold control and a trial code toward them, and reads back a single comparator decision bit.

All pins from the host are sampled with the fast system clock through a short synchronizer. Serial-clock and chip-select edges are found in that sampled domain, so the whole block runs on one clock with one synchronous reset. The data output comes with an enable that models a high-impedance pin. When the enable is low, the data line is also held low.

A frame has a fixed shape. Three zero slots come first: the level driven when chip select falls, then the values after the first two rising edges. Next come the twelve result bits, most significant first. Any further edges give zeros. Raising chip select ends the frame at any point. Pulling the shutdown input low also ends it, and it blocks new frames while it stays low.

Top module: `sar_serial_adc`

## Requirements
- R1: When chip select falls while shutdown_n is high, the block starts a frame. `dout_en` goes to 1, `dout` to 0 and `track` to 0 (hold), and `dac_code` loads the first trial code, which has only its most significant bit set (0x800).
- R2: While chip select is high, `dout_en` is 0 and `dout` is 0. The same holds out of reset, where `track` is 1 and `dac_code` is 0.
- R3: While `dout_en` stays 1, `dout` changes only after a rising serial-clock edge. A falling edge leaves it unchanged.
- R4: The first two rising edges of a frame leave `dout` at 0. The first result bit appears after the third rising edge.
- R5: Rising edge 3+k (k = 0..11) decides bit 11-k of `dac_code`. A comparator input of 1 keeps the bit and 0 clears it, and the decided bit is driven on `dout`. After edge 14, `dac_code` holds the straight unsigned binary result.
- R6: Rising edges after the 14th, with chip select still low, drive `dout` to 0 and leave `dac_code` unchanged.
- R7: `track` returns to 1 on the rising edge that decides the last bit, and also when chip select rises.
- R8: If chip select rises before the last bit is decided, the frame is aborted: `dout_en` goes to 0 and `track` to 1. The next falling edge of chip select starts again from the first trial code.
- R9: While shutdown_n is low, no frame starts and `dout_en` stays 0. Taking shutdown_n low aborts a running frame. Releasing it while chip select is already low does not start a frame; only a fresh falling edge of chip select does.
- R10: During a frame, the bits of `dac_code` above the bit under test never change on a deciding edge. The bit just below the decided bit is set as the next trial.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all host pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| shutdown_n | input | 1 | Active-low shutdown |
| cmp_in | input | 1 | Comparator decision: 1 when the held sample is at or above the trial level |
| dout | output | 1 | Serial data output |
| dout_en | output | 1 | Output drive enable; 0 models high impedance |
| track | output | 1 | 1 = track the input, 0 = hold the sample |
| dac_code | output | RES_BITS | Trial code for the capacitive DAC; after the last edge it holds the result |

## Verification
Most internal faults reach the ports within one serial-clock period. A wrong edge count moves the first result bit off the third edge, and the zero preamble is then visibly too short or too long. A trial register that fails to keep upper bits, or that sets the wrong next trial bit, shows up as a wrong `dac_code` right after that edge. Through the comparator loop it then also corrupts every later bit on `dout`. A sequencer that fails to leave its active phases on chip-select rise or shutdown shows up as `dout_en` or a low `track` lingering past the synchronizer delay. For this reason the bench checks `dac_code` and `dout` after every edge, not only at the end of the frame.

// File: rtl/sar_adc_pkg.sv
// Shared types for the serially clocked SAR sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package sar_adc_pkg;

    // Frame phases: tracking, zero preamble, bit resolution, zero trailer.
    typedef enum logic [1:0] {
        PH_TRACK   = 2'd0,
        PH_LEAD    = 2'd1,
        PH_RESOLVE = 2'd2,
        PH_TRAIL   = 2'd3
    } sar_phase_e;

endpackage

// File: rtl/sar_in_sync.sv
// Multi-flop synchronizer for a bus of independent single-bit host pins.
// Each bit has its own reset level so idle pins leave reset already idle.
// Assumes: STAGES >= 2 and the bits are unrelated (no bus coherence needed).
module sar_in_sync #(
    parameter int unsigned       WIDTH   = 4,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] pipe_q;

        // Shift the pin through STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe_q <= {STAGES{RST_VAL[i]}};
            end else begin
                pipe_q <= {pipe_q[STAGES-2:0], async_i[i]};
            end
        end

        assign sync_o[i] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/sar_ctrl.sv
// Frame sequencer: finds chip-select and serial-clock edges in the sampled
// domain, counts preamble edges, walks the bit index down, and drives the
// track/hold control. Emits one-cycle strobes for the datapath.
// Assumes: inputs are already synchronized; LEAD_EDGES >= 1.
module sar_ctrl
    import sar_adc_pkg::*;
#(
    parameter int unsigned RES_BITS   = 12,
    parameter int unsigned LEAD_EDGES = 2,
    localparam int unsigned IDX_W     = $clog2(RES_BITS),
    localparam int unsigned LCNT_W    = $clog2(LEAD_EDGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             cs_n_s,
    input  logic             shdn_n_s,
    output logic             start_o,
    output logic             step_o,
    output logic             trail_edge_o,
    output logic             stop_o,
    output logic [IDX_W-1:0] bit_idx_o,
    output logic             track_o
);

    sar_phase_e        phase_q;
    logic              sclk_d;
    logic              cs_d;
    logic              track_q;
    logic [LCNT_W-1:0] lead_cnt_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic              sclk_rise;
    logic              cs_fall;

    // Edge detection and frame strobes.
    always_comb begin
        sclk_rise    = sclk_s & ~sclk_d;
        cs_fall      = ~cs_n_s & cs_d;
        stop_o       = (phase_q != PH_TRACK) && (cs_n_s || !shdn_n_s);
        start_o      = (phase_q == PH_TRACK) && cs_fall && shdn_n_s;
        step_o       = (phase_q == PH_RESOLVE) && sclk_rise && !stop_o;
        trail_edge_o = (phase_q == PH_TRAIL) && sclk_rise && !stop_o;
    end

    // Phase, counters and track/hold control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d     <= 1'b0;
            cs_d       <= 1'b1;
            phase_q    <= PH_TRACK;
            track_q    <= 1'b1;
            lead_cnt_q <= '0;
            bit_idx_q  <= '0;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_n_s;
            if (stop_o) begin
                phase_q <= PH_TRACK;
                track_q <= 1'b1;
            end else begin
                case (phase_q)
                    PH_TRACK: begin
                        if (start_o) begin
                            phase_q    <= PH_LEAD;
                            track_q    <= 1'b0;
                            lead_cnt_q <= '0;
                            bit_idx_q  <= IDX_W'(RES_BITS - 1);
                        end
                    end
                    PH_LEAD: begin
                        if (sclk_rise) begin
                            lead_cnt_q <= lead_cnt_q + 1'b1;
                            if (lead_cnt_q == LCNT_W'(LEAD_EDGES - 1)) begin
                                phase_q <= PH_RESOLVE;
                            end
                        end
                    end
                    PH_RESOLVE: begin
                        if (sclk_rise) begin
                            if (bit_idx_q == '0) begin
                                phase_q <= PH_TRAIL;
                                track_q <= 1'b1;
                            end else begin
                                bit_idx_q <= bit_idx_q - 1'b1;
                            end
                        end
                    end
                    default: begin
                        phase_q <= PH_TRAIL;
                    end
                endcase
            end
        end
    end

    assign bit_idx_o = bit_idx_q;
    assign track_o   = track_q;

    AST_TRACK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TRACK) |-> track_q);  // R7
    AST_HOLD_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_LEAD) || (phase_q == PH_RESOLVE)) |-> !track_q);  // R1
    AST_CS_HIGH_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (phase_q == PH_TRACK));  // R8
    AST_SHDN_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n_s |=> (phase_q == PH_TRACK));  // R9

endmodule

// File: rtl/sar_trial_reg.sv
// Successive-approximation trial register. On start it loads the MSB-only
// trial. On each deciding edge it keeps or clears the bit under test from
// the comparator and sets the next lower bit as the new trial.
// Assumes: step_i only arrives while bit_idx_i points at a valid bit.
module sar_trial_reg #(
    parameter int unsigned RES_BITS = 12,
    localparam int unsigned IDX_W   = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                step_i,
    input  logic [IDX_W-1:0]    bit_idx_i,
    input  logic                cmp_i,
    output logic [RES_BITS-1:0] code_o
);

    localparam logic [RES_BITS-1:0] FIRST_TRIAL = RES_BITS'(1) << (RES_BITS - 1);

    logic [RES_BITS-1:0] code_q;

    // Load the first trial, then resolve one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (start_i) begin
            code_q <= FIRST_TRIAL;
        end else if (step_i) begin
            code_q[bit_idx_i] <= cmp_i;
            if (bit_idx_i != '0) begin
                code_q[bit_idx_i - 1'b1] <= 1'b1;
            end
        end
    end

    assign code_o = code_q;

    AST_UPPER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (((code_o ^ $past(code_o)) >> (int'($past(bit_idx_i)) + 1)) == '0));  // R10

endmodule

// File: rtl/sar_dout_stage.sv
// Serial output register and its drive enable. Drives low at frame start,
// takes each decided bit on the deciding edge, and pads zeros afterwards.
// Assumes: strobes from the sequencer are one cycle wide and exclusive.
module sar_dout_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_i,
    input  logic trail_edge_i,
    input  logic stop_i,
    input  logic cmp_i,
    output logic dout_o,
    output logic dout_en_o
);

    logic dout_q;
    logic en_q;

    // Update the output bit and enable from the frame strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (stop_i) begin
            dout_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (start_i) begin
            dout_q <= 1'b0;
            en_q   <= 1'b1;
        end else if (step_i) begin
            dout_q <= cmp_i;
        end else if (trail_edge_i) begin
            dout_q <= 1'b0;
        end
    end

    assign dout_o    = dout_q;
    assign dout_en_o = en_q;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en_o |-> !dout_o);  // R2
    AST_MOVES_ON_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en_o && $past(dout_en_o) && (dout_o != $past(dout_o)))
            |-> $past(step_i || trail_edge_i));  // R3
    AST_TRAIL_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trail_edge_i |=> !dout_o);  // R6

endmodule

// File: rtl/sar_serial_adc.sv
// Top of the serially clocked SAR sequencer. Synchronizes the host pins,
// sequences a frame (zero preamble, MSB-first bits, zero trailer), runs
// the trial register against the external comparator, and drives the
// serial output with its enable and the track/hold control.
// Assumes: the host serial clock is much slower than clk (several clk
// cycles per phase) and the comparator settles within one sclk period.
module sar_serial_adc #(
    parameter int unsigned RES_BITS    = 12,
    parameter int unsigned LEAD_EDGES  = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                shutdown_n,
    input  logic                cmp_in,
    output logic                dout,
    output logic                dout_en,
    output logic                track,
    output logic [RES_BITS-1:0] dac_code
);

    localparam int unsigned IDX_W = $clog2(RES_BITS);
    localparam int unsigned NPINS = 4;
    // Pin order: {cmp, shutdown_n, cs_n, sclk}; idle levels 0,1,1,0.
    localparam logic [NPINS-1:0] PIN_IDLE = 4'b0110;

    logic [NPINS-1:0] pins_s;
    logic             start;
    logic             step;
    logic             trail_edge;
    logic             stop;
    logic [IDX_W-1:0] bit_idx;

    sar_in_sync #(
        .WIDTH   (NPINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cmp_in, shutdown_n, cs_n, sclk}),
        .sync_o  (pins_s)
    );

    sar_ctrl #(
        .RES_BITS   (RES_BITS),
        .LEAD_EDGES (LEAD_EDGES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_s       (pins_s[0]),
        .cs_n_s       (pins_s[1]),
        .shdn_n_s     (pins_s[2]),
        .start_o      (start),
        .step_o       (step),
        .trail_edge_o (trail_edge),
        .stop_o       (stop),
        .bit_idx_o    (bit_idx),
        .track_o      (track)
    );

    sar_trial_reg #(
        .RES_BITS (RES_BITS)
    ) u_trial (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .step_i    (step),
        .bit_idx_i (bit_idx),
        .cmp_i     (pins_s[3]),
        .code_o    (dac_code)
    );

    sar_dout_stage u_dout (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .step_i       (step),
        .trail_edge_i (trail_edge),
        .stop_i       (stop),
        .cmp_i        (pins_s[3]),
        .dout_o       (dout),
        .dout_en_o    (dout_en)
    );

endmodule

// File: tb/sar_serial_adc_tb_top.sv
// Scoreboard bench: driver tasks push expected serial-output items into a
// queue; a monitor pops and compares them against the pins on each sample.
module sar_serial_adc_tb_top;

    localparam int N  = 12;
    localparam int HP = 8;   // clk cycles per sclk half period

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cs_n;
    logic         sclk;
    logic         shutdown_n;
    logic [N-1:0] vin;
    logic         dout;
    logic         dout_en;
    logic         track;
    logic [N-1:0] dac_code;
    logic         cmp_in;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic  exp_dout;
        logic  exp_en;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    always #2 clk = ~clk;

    // Behavioural comparator against the held sample.
    assign cmp_in = (vin >= dac_code);

    sar_serial_adc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .shutdown_n (shutdown_n),
        .cmp_in     (cmp_in),
        .dout       (dout),
        .dout_en    (dout_en),
        .track      (track),
        .dac_code   (dac_code)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Monitor: pop expected items and compare with {dout_en, dout}.
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk((dout === e.exp_dout) && (dout_en === e.exp_en), e.tag,
                    "{dout_en,dout}", {dout_en, dout}, {e.exp_en, e.exp_dout});
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic d, input logic en, input string tag);
        exp_t e;
        e.exp_dout = d;
        e.exp_en   = en;
        e.tag      = tag;
        exp_q.push_back(e);
        -> sample_ev;
        @(negedge clk);
    endtask

    task automatic sclk_rise();
        sclk = 1'b1;
        wait_clk(HP);
    endtask

    task automatic sclk_fall();
        sclk = 1'b0;
        wait_clk(HP);
    endtask

    // One frame with n_edges rising edges for sample v.
    task automatic conv(input logic [N-1:0] v, input int n_edges);
        vin  = v;
        cs_n = 1'b0;
        wait_clk(HP);
        expect_out(1'b0, 1'b1, "R1 start");
        chk(track === 1'b0, "R1", "track at start", track, 0);
        chk(dac_code === 12'h800, "R1", "first trial", dac_code, 12'h800);
        for (int e = 1; e <= n_edges; e++) begin
            logic  expb;
            string tg;
            if (e <= 2) begin
                expb = 1'b0;
                tg   = "R4 preamble";
            end else if (e <= 14) begin
                expb = v[14 - e];
                tg   = "R5 bit";
            end else begin
                expb = 1'b0;
                tg   = "R6 trailer";
            end
            sclk_rise();
            expect_out(expb, 1'b1, tg);
            if (e >= 3 && e <= 14) begin
                int k;
                logic [N-1:0] expc;
                k    = 14 - e;
                expc = (v >> k) << k;
                if (k > 0) expc = expc | (N'(1) << (k - 1));
                chk(dac_code === expc, "R10", "trial after edge", dac_code, expc);
            end
            if (e == 13) chk(track === 1'b0, "R7", "hold before last bit", track, 0);
            if (e == 14) begin
                chk(track === 1'b1, "R7", "track after last bit", track, 1);
                chk(dac_code === v, "R5", "final code", dac_code, v);
            end
            if (e > 14) chk(dac_code === v, "R6", "code kept", dac_code, v);
            sclk_fall();
            expect_out(expb, 1'b1, "R3 stable on fall");
        end
        cs_n = 1'b1;
        wait_clk(HP);
        expect_out(1'b0, 1'b0, "R2 cs high");
        chk(track === 1'b1, "R7", "track on cs rise", track, 1);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        cs_n       = 1'b1;
        sclk       = 1'b0;
        shutdown_n = 1'b1;
        vin        = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);

        // R2: reset state.
        expect_out(1'b0, 1'b0, "R2 reset");
        chk(track === 1'b1, "R2", "track after reset", track, 1);
        chk(dac_code === '0, "R2", "code after reset", dac_code, 0);

        // Main function across several samples.
        conv(12'hA5C, 16);
        conv(12'hFFF, 15);
        conv(12'h000, 15);
        conv(12'h001, 16);
        conv(12'h800, 15);

        // R8: abort mid-frame, then restart.
        vin  = 12'h3C3;
        cs_n = 1'b0;
        wait_clk(HP);
        for (int e = 0; e < 7; e++) begin
            sclk_rise();
            sclk_fall();
        end
        cs_n = 1'b1;
        wait_clk(HP);
        expect_out(1'b0, 1'b0, "R8 abort");
        chk(track === 1'b1, "R8", "track after abort", track, 1);
        cs_n = 1'b0;
        wait_clk(HP);
        chk(dac_code === 12'h800, "R8", "restart trial", dac_code, 12'h800);
        cs_n = 1'b1;
        wait_clk(HP);
        conv(12'h155, 15);

        // R9: shutdown blocks frames.
        shutdown_n = 1'b0;
        wait_clk(HP);
        cs_n = 1'b0;
        wait_clk(HP);
        expect_out(1'b0, 1'b0, "R9 cs fall in shutdown");
        chk(track === 1'b1, "R9", "track in shutdown", track, 1);
        sclk_rise();
        sclk_fall();
        expect_out(1'b0, 1'b0, "R9 edge in shutdown");
        shutdown_n = 1'b1;
        wait_clk(HP);
        sclk_rise();
        sclk_fall();
        expect_out(1'b0, 1'b0, "R9 release with cs low");
        cs_n = 1'b1;
        wait_clk(HP);
        conv(12'h7FF, 15);

        // R9: shutdown aborts a running frame.
        vin  = 12'h9A6;
        cs_n = 1'b0;
        wait_clk(HP);
        for (int e = 0; e < 5; e++) begin
            sclk_rise();
            sclk_fall();
        end
        shutdown_n = 1'b0;
        wait_clk(HP);
        expect_out(1'b0, 1'b0, "R9 shutdown mid-frame");
        chk(track === 1'b1, "R9", "track after shutdown abort", track, 1);
        shutdown_n = 1'b1;
        cs_n       = 1'b1;
        wait_clk(HP);
        conv(12'h2B4, 15);

        wait_clk(4);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule